// File: doc/BRIEF.md
# Segment Selector Validation Unit

This block is a purely combinational checker. It takes a 16-bit segment selector and the 64-bit descriptor already fetched for it. It judges the pair against the current privilege level (CPL) and the processor mode. A 4-bit check kind chooses which rule set applies. It reports whether a fault is raised, the fault class, and the 16-bit error code that goes with it. Codes with no rule set are flagged as unsupported.

The block also updates a flag word on every evaluation. Flag bits chosen by an enable mask are cleared. They are then set again when the selector is null. A null selector is one whose index and table-indicator bits are all zero, whatever its requested privilege. The table lookup that supplies the descriptor happens outside the block.

Top module: `seg_guard`

## Requirements
- R1: Field positions. Selector: RPL is bits 1:0, TI is bit 2, index is bits 15:3. A selector is null when bits 15:2 are zero. Descriptor: type is bits 43:40, S is bit 44, DPL is bits 46:45, P is bit 47, L is bit 53, D is bit 54. Kind code 0 (no check) never faults.
- R2: Kind codes 1 and 2, and codes 9 to 15, set `unsup_o` and leave `fault_o` low. Every other code keeps `unsup_o` low.
- R3: Kind 4 (software interrupt gate) raises GP with the selector as error code when DPL < CPL. It then applies the kind 3 rule, and a failure under that rule takes precedence with error code 0.
- R4: Kind 3 (interrupt gate) raises GP with error code 0 in either of two cases: in long mode when (type & 0xE) != 0xE, or in any mode when (type & 0x6) != 0x6.
- R5: Kind 5 (stack segment) with a non-null selector and P = 0 raises a stack fault with the selector as error code.
- R6: Kind 5 with a null selector raises GP (selector as error code) unless all of these hold: `sub64_i` is 1, CPL != 3, S = 1, type bit 3 = 0, type bit 1 = 1, DPL = CPL and RPL = CPL.
- R7: Kind 6 (interrupt return) raises GP (selector as error code) in any of these cases: the selector is null; RPL < CPL; the descriptor is not a code segment (S = 0 or type bit 3 = 0); type bit 2 = 0 and DPL != RPL; type bit 2 = 1 and DPL > RPL.
- R8: Kind 6, when none of the R7 conditions holds and P = 0, raises segment-not-present with the selector as error code.
- R9: Kind 7 (interrupt code segment) in long mode raises GP (selector as error code) unless L = 1 and D = 0. Outside long mode it does not fault.
- R10: Kind 8 (task register) raises GP (selector as error code) when the selector is null or TI = 1.
- R11: `flags_o` equals `flags_i` with the `zmask_i` bits cleared. The `zmask_i` bits are then set again when the selector is null. This applies for every kind code.
- R12: Fault class encoding is 0 none, 1 GP, 2 stack fault, 3 not present. When `fault_o` is 0, `fclass_o` and `ferr_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_i | input | 16 | Segment selector |
| desc_i | input | 64 | Descriptor fetched for the selector |
| kind_i | input | 4 | Check kind code |
| cpl_i | input | 2 | Current privilege level |
| long_i | input | 1 | Long mode active |
| sub64_i | input | 1 | 64-bit submode active |
| flags_i | input | FLAG_W | Incoming flag word |
| zmask_i | input | FLAG_W | Zero-flag enable mask |
| fault_o | output | 1 | Fault raised |
| fclass_o | output | 2 | Fault class |
| ferr_o | output | 16 | Fault error code |
| unsup_o | output | 1 | Kind code has no rule set |
| flags_o | output | FLAG_W | Updated flag word |

## Verification
The hardest corner to reach is the null-selector stack case that passes. Seven independent conditions must hold at once, so random stimulus almost never produces it. A second hard corner is the software-interrupt gate where both the privilege rule and the gate-type rule fail, because only the error code shows which rule won. Directed vectors build both cases from field-level descriptor helpers. A large biased sweep then runs a small field alphabet against an independent model, with null selectors and privilege-matching fields drawn often.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

  localparam int SEL_W  = 16;
  localparam int DESC_W = 64;

  localparam logic [3:0] CK_NONE  = 4'd0;
  localparam logic [3:0] CK_CODE  = 4'd1;
  localparam logic [3:0] CK_CALLG = 4'd2;
  localparam logic [3:0] CK_INTG  = 4'd3;
  localparam logic [3:0] CK_SWINT = 4'd4;
  localparam logic [3:0] CK_STACK = 4'd5;
  localparam logic [3:0] CK_IRET  = 4'd6;
  localparam logic [3:0] CK_INTCS = 4'd7;
  localparam logic [3:0] CK_TASK  = 4'd8;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_GP   = 2'd1,
    FC_SS   = 2'd2,
    FC_NP   = 2'd3
  } fclass_e;

  typedef struct packed {
    logic [1:0] rpl;
    logic       ti;
    logic       nul;
    logic [1:0] dpl;
    logic       present;
    logic       sys_n;
    logic [3:0] ty;
    logic       lbit;
    logic       dbit;
  } seg_fields_t;

  function automatic logic is_code_seg(seg_fields_t f);
    return f.sys_n && f.ty[3];
  endfunction

  function automatic logic is_wr_data(seg_fields_t f);
    return f.sys_n && !f.ty[3] && f.ty[1];
  endfunction

  function automatic logic gate_type_bad(seg_fields_t f, logic lm);
    return (lm && (f.ty & 4'hE) != 4'hE) || ((f.ty & 4'h6) != 4'h6);
  endfunction

endpackage

// File: rtl/seg_guard_decode.sv
module seg_guard_decode
  import seg_guard_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DESC_W-1:0] desc_i,
  output seg_fields_t       fld_o
);

  always_comb begin
    fld_o.rpl     = sel_i[1:0];
    fld_o.ti      = sel_i[2];
    fld_o.nul     = (sel_i[SEL_W-1:2] == '0);
    fld_o.ty      = desc_i[43:40];
    fld_o.sys_n   = desc_i[44];
    fld_o.dpl     = desc_i[46:45];
    fld_o.present = desc_i[47];
    fld_o.lbit    = desc_i[53];
    fld_o.dbit    = desc_i[54];
  end

  always_comb begin
    if (fld_o.ti) a_r1_null_has_no_ti: assert (!fld_o.nul);
  end

endmodule

// File: rtl/seg_guard_rules.sv
module seg_guard_rules
  import seg_guard_pkg::*;
(
  input  seg_fields_t      fld_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [3:0]       kind_i,
  input  logic [1:0]       cpl_i,
  input  logic             long_i,
  input  logic             sub64_i,
  output logic             fault_o,
  output fclass_e          fclass_o,
  output logic [SEL_W-1:0] ferr_o,
  output logic             unsup_o
);

  logic gate_bad;
  logic swint_priv_bad;
  logic stack_null_ok;
  logic iret_bad;
  logic cs64_bad;

  assign gate_bad       = gate_type_bad(fld_i, long_i);
  assign swint_priv_bad = (fld_i.dpl < cpl_i);
  assign stack_null_ok  = sub64_i && (cpl_i != 2'd3) && is_wr_data(fld_i)
                          && (fld_i.dpl == cpl_i) && (fld_i.rpl == cpl_i);
  assign iret_bad       = fld_i.nul || (fld_i.rpl < cpl_i) || !is_code_seg(fld_i)
                          || (!fld_i.ty[2] && (fld_i.dpl != fld_i.rpl))
                          || (fld_i.ty[2] && (fld_i.dpl > fld_i.rpl));
  assign cs64_bad       = long_i && (!fld_i.lbit || fld_i.dbit);

  always_comb begin
    fault_o  = 1'b0;
    fclass_o = FC_NONE;
    ferr_o   = '0;
    unsup_o  = 1'b0;
    case (kind_i)
      CK_NONE: ;
      CK_INTG, CK_SWINT: begin
        if (kind_i == CK_SWINT && swint_priv_bad) begin
          fault_o = 1'b1; fclass_o = FC_GP; ferr_o = sel_i;
        end
        if (gate_bad) begin
          fault_o = 1'b1; fclass_o = FC_GP; ferr_o = '0;
        end
      end
      CK_STACK: begin
        if (!fld_i.nul) begin
          if (!fld_i.present) begin
            fault_o = 1'b1; fclass_o = FC_SS; ferr_o = sel_i;
          end
        end else if (!stack_null_ok) begin
          fault_o = 1'b1; fclass_o = FC_GP; ferr_o = sel_i;
        end
      end
      CK_IRET: begin
        if (iret_bad) begin
          fault_o = 1'b1; fclass_o = FC_GP; ferr_o = sel_i;
        end else if (!fld_i.present) begin
          fault_o = 1'b1; fclass_o = FC_NP; ferr_o = sel_i;
        end
      end
      CK_INTCS: begin
        if (cs64_bad) begin
          fault_o = 1'b1; fclass_o = FC_GP; ferr_o = sel_i;
        end
      end
      CK_TASK: begin
        if (fld_i.nul || fld_i.ti) begin
          fault_o = 1'b1; fclass_o = FC_GP; ferr_o = sel_i;
        end
      end
      default: unsup_o = 1'b1;
    endcase
  end

  always_comb begin
    if (unsup_o) a_r2_unsup_no_fault: assert (!fault_o);
    if (!fault_o) a_r12_quiet_outputs: assert (fclass_o == FC_NONE && ferr_o == '0);
    if (kind_i == CK_STACK && !fld_i.nul && !fld_i.present)
      a_r5_stack_absent: assert (fault_o && fclass_o == FC_SS);
    if (kind_i == CK_TASK && fld_i.ti)
      a_r10_task_local: assert (fault_o && fclass_o == FC_GP);
    if (kind_i == CK_INTG && gate_bad)
      a_r4_gate_zero_err: assert (fault_o && ferr_o == '0);
  end

endmodule

// File: rtl/seg_guard_zflag.sv
module seg_guard_zflag #(
  parameter int FLAG_W = 8
) (
  input  logic              nul_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] zmask_i,
  output logic [FLAG_W-1:0] flags_o
);

  logic [FLAG_W-1:0] cleared;

  assign cleared = flags_i & ~zmask_i;
  assign flags_o = nul_i ? (cleared | zmask_i) : cleared;

  always_comb begin
    if (!$isunknown({flags_i, zmask_i, nul_i}))
      a_r11_outside_mask_kept: assert ((flags_o & ~zmask_i) == (flags_i & ~zmask_i));
  end

endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int FLAG_W = 8
) (
  input  logic [15:0]       sel_i,
  input  logic [63:0]       desc_i,
  input  logic [3:0]        kind_i,
  input  logic [1:0]        cpl_i,
  input  logic              long_i,
  input  logic              sub64_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] zmask_i,
  output logic              fault_o,
  output logic [1:0]        fclass_o,
  output logic [15:0]       ferr_o,
  output logic              unsup_o,
  output logic [FLAG_W-1:0] flags_o
);

  seg_fields_t fld;
  fclass_e     cls;

  seg_guard_decode u_decode (
    .sel_i  (sel_i),
    .desc_i (desc_i),
    .fld_o  (fld)
  );

  seg_guard_rules u_rules (
    .fld_i    (fld),
    .sel_i    (sel_i),
    .kind_i   (kind_i),
    .cpl_i    (cpl_i),
    .long_i   (long_i),
    .sub64_i  (sub64_i),
    .fault_o  (fault_o),
    .fclass_o (cls),
    .ferr_o   (ferr_o),
    .unsup_o  (unsup_o)
  );

  assign fclass_o = cls;

  seg_guard_zflag #(.FLAG_W(FLAG_W)) u_zflag (
    .nul_i   (fld.nul),
    .flags_i (flags_i),
    .zmask_i (zmask_i),
    .flags_o (flags_o)
  );

endmodule

// File: tb/seg_guard_bench.sv
module seg_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FW         = 8;
  localparam int WATCHDOG   = 150000;
  localparam int SWEEP      = 40000;

  logic          clk = 1'b0;
  logic [15:0]   sel;
  logic [63:0]   desc;
  logic [3:0]    kind;
  logic [1:0]    cpl;
  logic          lm, s64;
  logic [FW-1:0] fin, zm;
  logic          fault, unsup;
  logic [1:0]    fcls;
  logic [15:0]   ferr;
  logic [FW-1:0] fout;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_guard #(.FLAG_W(FW)) u_seg_guard (
    .sel_i(sel), .desc_i(desc), .kind_i(kind), .cpl_i(cpl), .long_i(lm),
    .sub64_i(s64), .flags_i(fin), .zmask_i(zm), .fault_o(fault),
    .fclass_o(fcls), .ferr_o(ferr), .unsup_o(unsup), .flags_o(fout)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [63:0] mkd(int ty, int s, int dpl, int p, int l, int d);
    logic [63:0] r;
    r = 64'h0;
    r[43:40] = 4'(ty); r[44] = 1'(s); r[46:45] = 2'(dpl);
    r[47] = 1'(p); r[53] = 1'(l); r[54] = 1'(d);
    return r;
  endfunction

  // independent model: returns {unsup, fault, class[1:0], err[15:0]}
  function automatic logic [19:0] model(logic [15:0] sl, logic [63:0] ds, int k,
                                        int cp, int lmi, int sb);
    int rp, dp, ty, sg, pr, nl;
    int f, c, e;
    rp = int'(sl[1:0]); nl = (sl[15:2] == 0) ? 1 : 0;
    ty = int'(ds[43:40]); sg = int'(ds[44]); dp = int'(ds[46:45]); pr = int'(ds[47]);
    f = 0; c = 0; e = 0;
    if (k == 1 || k == 2 || k > 8) return {1'b1, 1'b0, 2'd0, 16'h0};
    if (k == 3 || k == 4) begin
      if (k == 4 && dp < cp) begin f = 1; c = 1; e = int'(sl); end
      if ((lmi != 0 && ty < 14) || (ty % 8) < 6) begin f = 1; c = 1; e = 0; end
    end else if (k == 5) begin
      if (nl == 0) begin
        if (pr == 0) begin f = 1; c = 2; e = int'(sl); end
      end else if (!(sb == 1 && cp != 3 && sg == 1 && ty < 8 && (ty / 2) % 2 == 1
                     && dp == cp && rp == cp)) begin
        f = 1; c = 1; e = int'(sl);
      end
    end else if (k == 6) begin
      if (nl == 1 || rp < cp || sg == 0 || ty < 8 ||
          (ty < 12 && dp != rp) || (ty >= 12 && dp > rp)) begin
        f = 1; c = 1; e = int'(sl);
      end else if (pr == 0) begin f = 1; c = 3; e = int'(sl); end
    end else if (k == 7) begin
      if (lmi != 0 && !(ds[53] == 1'b1 && ds[54] == 1'b0)) begin f = 1; c = 1; e = int'(sl); end
    end else if (k == 8) begin
      if (nl == 1 || sl[2] == 1'b1) begin f = 1; c = 1; e = int'(sl); end
    end
    return {1'b0, 1'(f), 2'(c), 16'(e)};
  endfunction

  function automatic string tag_of(int k);
    case (k)
      0: return "R1"; 3: return "R4"; 4: return "R3"; 5: return "R6";
      6: return "R7"; 7: return "R9"; 8: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic drive(logic [15:0] sl, logic [63:0] ds, int k, int cp, int lmi, int sb,
                       logic [FW-1:0] fi, logic [FW-1:0] zmi);
    @(negedge clk);
    sel = sl; desc = ds; kind = 4'(k); cpl = 2'(cp); lm = 1'(lmi); s64 = 1'(sb);
    fin = fi; zm = zmi;
    #1;
  endtask

  task automatic check_out(string tg, logic [19:0] exp);
    total = total + 1;
    if ({unsup, fault, fcls, ferr} !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual unsup=%b fault=%b cls=%0d err=%h expected unsup=%b fault=%b cls=%0d err=%h",
               tg, unsup, fault, fcls, ferr, exp[19], exp[18], exp[17:16], exp[15:0]);
    end
  endtask

  task automatic check_flags(string tg, logic [FW-1:0] exp);
    total = total + 1;
    if (fout !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual flags=%h expected=%h", tg, fout, exp);
    end
  endtask

  initial begin
    sel = '0; desc = '0; kind = '0; cpl = '0; lm = 0; s64 = 0; fin = '0; zm = '0;
    repeat (2) @(negedge clk);
    #1;
    // R1: kind 0 with all-zero inputs is quiet; R11 null sets masked flags
    check_out("R1", {1'b0, 1'b0, 2'd0, 16'h0});
    drive(16'h0008, mkd(0, 0, 0, 0, 0, 0), 0, 3, 1, 1, 8'hF0, 8'h0F);
    check_out("R1", {1'b0, 1'b0, 2'd0, 16'h0});
    check_flags("R11", 8'hF0);
    drive(16'h0003, mkd(0, 0, 0, 0, 0, 0), 5, 0, 0, 0, 8'hAA, 8'h41);
    check_flags("R11", 8'hEB);
    // R2
    drive(16'h0010, mkd(14, 0, 0, 1, 0, 0), 1, 0, 0, 0, 8'h0, 8'h0);
    check_out("R2", {1'b1, 1'b0, 2'd0, 16'h0});
    drive(16'h0010, mkd(14, 0, 0, 1, 0, 0), 15, 0, 0, 0, 8'h0, 8'h0);
    check_out("R2", {1'b1, 1'b0, 2'd0, 16'h0});
    // R3: privilege fault alone, then both rules fail (gate wins, err 0)
    drive(16'h0023, mkd(14, 0, 0, 1, 0, 0), 4, 3, 1, 1, 8'h0, 8'h0);
    check_out("R3", {1'b0, 1'b1, 2'd1, 16'h0023});
    drive(16'h0023, mkd(12, 0, 0, 1, 0, 0), 4, 3, 1, 1, 8'h0, 8'h0);
    check_out("R3", {1'b0, 1'b1, 2'd1, 16'h0000});
    // R4: 0x6 legal outside long mode, illegal in long mode
    drive(16'h0040, mkd(6, 0, 0, 1, 0, 0), 3, 0, 0, 0, 8'h0, 8'h0);
    check_out("R4", {1'b0, 1'b0, 2'd0, 16'h0});
    drive(16'h0040, mkd(6, 0, 0, 1, 0, 0), 3, 0, 1, 1, 8'h0, 8'h0);
    check_out("R4", {1'b0, 1'b1, 2'd1, 16'h0});
    // R5
    drive(16'h0058, mkd(2, 1, 0, 0, 0, 0), 5, 0, 0, 0, 8'h0, 8'h0);
    check_out("R5", {1'b0, 1'b1, 2'd2, 16'h0058});
    // R6: all-conditions pass, then one broken (rpl)
    drive(16'h0001, mkd(2, 1, 1, 1, 0, 0), 5, 1, 1, 1, 8'h0, 8'h0);
    check_out("R6", {1'b0, 1'b0, 2'd0, 16'h0});
    drive(16'h0002, mkd(2, 1, 1, 1, 0, 0), 5, 1, 1, 1, 8'h0, 8'h0);
    check_out("R6", {1'b0, 1'b1, 2'd1, 16'h0002});
    // R7 / R8
    drive(16'h0062, mkd(10, 1, 2, 1, 0, 0), 6, 1, 0, 0, 8'h0, 8'h0);
    check_out("R7", {1'b0, 1'b0, 2'd0, 16'h0});
    drive(16'h0062, mkd(14, 1, 3, 1, 0, 0), 6, 1, 0, 0, 8'h0, 8'h0);
    check_out("R7", {1'b0, 1'b1, 2'd1, 16'h0062});
    drive(16'h0062, mkd(14, 1, 1, 0, 0, 0), 6, 1, 0, 0, 8'h0, 8'h0);
    check_out("R8", {1'b0, 1'b1, 2'd3, 16'h0062});
    // R9
    drive(16'h0070, mkd(10, 1, 0, 1, 1, 1), 7, 0, 1, 1, 8'h0, 8'h0);
    check_out("R9", {1'b0, 1'b1, 2'd1, 16'h0070});
    drive(16'h0070, mkd(10, 1, 0, 1, 1, 1), 7, 0, 0, 0, 8'h0, 8'h0);
    check_out("R9", {1'b0, 1'b0, 2'd0, 16'h0});
    // R10
    drive(16'h0084, mkd(9, 0, 0, 1, 0, 0), 8, 0, 0, 0, 8'h0, 8'h0);
    check_out("R10", {1'b0, 1'b1, 2'd1, 16'h0084});
    drive(16'h0080, mkd(9, 0, 0, 1, 0, 0), 8, 0, 0, 0, 8'h0, 8'h0);
    check_out("R10", {1'b0, 1'b0, 2'd0, 16'h0});

    // biased sweep against the model (R12 covered by quiet-output comparison)
    for (int i = 0; i < SWEEP; i++) begin
      logic [15:0] sl;
      logic [63:0] ds;
      logic [FW-1:0] fi, zmi, fe;
      int k, cp;
      k  = $urandom_range(0, 15);
      cp = $urandom_range(0, 3);
      sl = ($urandom_range(0, 2) == 0) ? 16'($urandom_range(0, 3)) : 16'($urandom);
      if ($urandom_range(0, 1) == 0) sl[1:0] = 2'(cp);
      ds = mkd($urandom_range(0, 15), $urandom_range(0, 1),
               ($urandom_range(0, 1) == 0) ? cp : $urandom_range(0, 3),
               $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      fi = FW'($urandom); zmi = FW'($urandom);
      drive(sl, ds, k, cp, $urandom_range(0, 1), $urandom_range(0, 1), fi, zmi);
      check_out(tag_of(k), model(sl, ds, k, cp, int'(lm), int'(s64)));
      fe = (fi & ~zmi) | ((sl[15:2] == 0) ? zmi : '0);
      check_flags("R11", fe);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule